// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block sits behind a host byte channel and turns a stream of one-byte commands into register accesses. The high four bits of each byte choose what happens and the low four bits carry a value. Because each command carries only four bits of payload, it takes two commands to build an eight-bit register address and two to build an eight-bit write value. A read places one whole byte on a response stream that has valid/ready handshaking. A read can optionally move the address up or down by one after it runs, so a host can sweep through a range of registers with a single repeated command byte.

There are two register banks, and they are independent of each other. The write bank is the control state that the block drives out to neighbouring logic. The read bank holds values that neighbouring logic loads through per-register strobes. Only the lowest sixteen addresses are backed by real registers. Command bytes with opcodes the block does not handle are passed to an auxiliary output so that other units can act on them.

Top module: `nibcmd_regport`

## Requirements
- R1: The block takes a command byte when `cmd_valid` and `cmd_ready` are both high at a clock edge. Bits 7:4 of the byte are the opcode and bits 3:0 are the operand.
- R2: Opcode 0x0 copies the operand into address bits 3:0. Opcode 0x1 copies it into address bits 7:4. In both cases the other half of the address keeps its value.
- R3: Opcode 0x2 stores the operand as the pending low data nibble. Opcode 0x3 writes {operand, pending nibble} into write register `addr`, which appears on `wr_regs` bits 8*addr+7 down to 8*addr.
- R4: Opcode 0x4 returns the read register at the current address as one byte on `rsp_data`. Read register i loads `stat_data` in any cycle where `stat_we[i]` is high.
- R5: A write to address 0x10 or above changes no register. A read from address 0x10 or above returns 0xFF.
- R6: For opcode 0x4, operand bit 0 enables an address change after the read and operand bit 1 picks the direction (1 = decrement, 0 = increment).
  - The address wraps modulo 256.
  - The response always comes from the address as it was before the change.
- R7: A response stays valid with stable data until `rsp_ready` accepts it.
  - `cmd_ready` equals `!rsp_valid || rsp_ready`, so commands stall only while a response is blocked.
- R8: A command with opcode 0x5 to 0xF is accepted without any stall.
  - In the cycle it is accepted, `aux_valid` is high and `aux_data` carries the whole byte.
  - It changes neither the address nor the pending data nibble.
- R9: A synchronous reset clears the address, the pending nibble, both register banks and the response valid flag to zero.
- R10: Only an opcode 0x3 command can change `wr_regs`. Writes never move the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_data | input | 8 | Command byte: opcode in bits 7:4, operand in bits 3:0 |
| cmd_ready | output | 1 | The block can take a command this cycle |
| rsp_valid | output | 1 | A read response byte is waiting |
| rsp_data | output | 8 | Read response byte |
| rsp_ready | input | 1 | The consumer takes the response this cycle |
| aux_valid | output | 1 | An unhandled opcode was accepted this cycle |
| aux_data | output | 8 | The byte passed on to other units |
| stat_we | input | 16 | Per-register load strobes for the read bank |
| stat_data | input | 8 | Value loaded into the strobed read registers |
| wr_regs | output | 128 | Write bank, register i in bits 8i+7:8i |

## Verification
The bench targets the cases where an address is built or moved near a boundary:
- Auto-increment across 0x0F to 0x10 must switch the reply from a real register to 0xFF. A design that compares only the low nibble would instead alias back to register 0.
- Wrapping from 0xFF to 0x00 must land on register 0. A design that saturates would keep answering 0xFF.
- Decrementing from 0x00 must return register 0 first, before the address moves.

It checks that the two banks are independent by reading an address right after writing it; a design that shares one bank would return the written byte.

It puts an auxiliary opcode between the two halves of a write, so a design that clobbers the pending nibble would commit the wrong byte.

It throttles `rsp_ready` to check that responses are not lost, reordered or changed while commands stall.

// File: rtl/nibcmd_regport.sv
module nibcmd_regport #(
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_data,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  input  logic              rsp_ready,
  output logic              aux_valid,
  output logic [7:0]        aux_data,
  input  logic [NREG-1:0]   stat_we,
  input  logic [7:0]        stat_data,
  output logic [NREG*8-1:0] wr_regs
);
  localparam int IW = $clog2(NREG);

  logic [7:0]  addr;
  logic [3:0]  dlo;
  logic [7:0]  wreg [NREG];
  logic [7:0]  rreg [NREG];

  wire        acc      = cmd_valid && cmd_ready;
  wire [3:0]  op       = cmd_data[7:4];
  wire [3:0]  opd      = cmd_data[3:0];
  wire        in_range = addr < 8'(NREG);
  wire [IW-1:0] idx    = addr[IW-1:0];

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign aux_valid = acc && (op >= 4'h5);
  assign aux_data  = cmd_data;

  for (genvar i = 0; i < NREG; i++) begin : g_out
    assign wr_regs[i*8 +: 8] = wreg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr      <= '0;
      dlo       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      for (int i = 0; i < NREG; i++) begin
        wreg[i] <= '0;
        rreg[i] <= '0;
      end
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (acc) begin
        case (op)
          4'h0: addr[3:0] <= opd;
          4'h1: addr[7:4] <= opd;
          4'h2: dlo <= opd;
          4'h3: if (in_range) wreg[idx] <= {opd, dlo};
          4'h4: begin
            rsp_valid <= 1'b1;
            rsp_data  <= in_range ? rreg[idx] : 8'hFF;
            if (opd[0]) addr <= opd[1] ? addr - 8'd1 : addr + 8'd1;
          end
          default: ;
        endcase
      end
      for (int i = 0; i < NREG; i++)
        if (stat_we[i]) rreg[i] <= stat_data;
    end
  end
endmodule

module nibcmd_regport_chk #(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [7:0]        cmd_data,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic [7:0]        rsp_data,
  input logic              rsp_ready,
  input logic              aux_valid,
  input logic [NREG*8-1:0] wr_regs,
  input logic [7:0]        addr
);
  wire acc = cmd_valid && cmd_ready;

  p_ff_beyond_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_data[7:4] == 4'h4 && addr >= 8'(NREG)) |=> (rsp_valid && rsp_data == 8'hFF));

  p_inc_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_data[7:4] == 4'h4 && cmd_data[1:0] == 2'b01) |=> (addr == $past(addr) + 8'd1));

  p_dec_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_data[7:4] == 4'h4 && cmd_data[1:0] == 2'b11) |=> (addr == $past(addr) - 8'd1));

  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);

  p_aux_only_r8: assert property (@(posedge clk) disable iff (rst)
    aux_valid |-> (acc && cmd_data[7:4] >= 4'h5));

  p_aux_keeps_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_data[7:4] >= 4'h5) |=> $stable(addr));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (addr == 8'd0 && !rsp_valid && wr_regs == '0));

  p_wr_only_commit_r10: assert property (@(posedge clk) disable iff (rst)
    !(acc && cmd_data[7:4] == 4'h3) |=> $stable(wr_regs));
endmodule

bind nibcmd_regport nibcmd_regport_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
  .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_ready(rsp_ready), .aux_valid(aux_valid), .wr_regs(wr_regs),
  .addr(addr)
);

// File: tb/nibcmd_regport_bench.sv
`timescale 1ns/1ps
module nibcmd_regport_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [7:0]   cmd_data = 8'h00;
  logic         cmd_ready;
  logic         rsp_valid;
  logic [7:0]   rsp_data;
  logic         rsp_ready;
  logic         aux_valid;
  logic [7:0]   aux_data;
  logic [15:0]  stat_we = '0;
  logic [7:0]   stat_data = 8'h00;
  logic [127:0] wr_regs;

  always #4 clk = ~clk;

  nibcmd_regport u_nibcmd_regport (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready), .aux_valid(aux_valid), .aux_data(aux_data),
    .stat_we(stat_we), .stat_data(stat_data), .wr_regs(wr_regs)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q [$];
  logic [7:0] exp_wr [16];
  logic [7:0] exp_rd [16];
  logic [7:0] m_addr;
  bit   slow = 1'b0;
  bit   aux_seen;
  logic [7:0] aux_byte;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: drives rsp_ready and pops the scoreboard
  int   cyc = 0;
  bit   hold_chk = 1'b0;
  logic [7:0] held;
  always @(negedge clk) begin
    if (rst) begin
      rsp_ready = 1'b1;
      hold_chk  = 1'b0;
    end else begin
      bit r;
      logic [7:0] e;
      cyc++;
      if (hold_chk) chk(rsp_valid && rsp_data == held, "R7 blocked response held", rsp_data, held);
      r = slow ? (cyc % 3 == 0) : 1'b1;
      rsp_ready = r;
      hold_chk = rsp_valid && !r;
      held = rsp_data;
      if (rsp_valid && r) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected response", rsp_data, 8'h00);
        else begin
          e = exp_q.pop_front();
          chk(rsp_data == e, "R4/R5/R6 response byte", rsp_data, e);
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    cmd_data  = b;
    cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin
      chk(rsp_valid && !rsp_ready, "R7 stall only on blocked response", {7'd0, rsp_valid}, 8'd1);
      @(negedge clk); #1;
    end
    aux_seen = aux_valid;
    aux_byte = aux_data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
    m_addr = a;
  endtask

  task automatic wr(input logic [7:0] v);
    send({4'h2, v[3:0]});
    send({4'h3, v[7:4]});
    if (m_addr < 8'd16) exp_wr[m_addr[3:0]] = v;
  endtask

  task automatic rd(input logic [1:0] mode);
    exp_q.push_back(m_addr < 8'd16 ? exp_rd[m_addr[3:0]] : 8'hFF);
    send({4'h4, 2'b00, mode});
    if (mode[0]) m_addr = mode[1] ? m_addr - 8'd1 : m_addr + 8'd1;
  endtask

  task automatic load_rd(input int i, input logic [7:0] v);
    stat_we = 16'(1) << i;
    stat_data = v;
    @(negedge clk);
    stat_we = '0;
    exp_rd[i] = v;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic check_wr(input string tag);
    for (int i = 0; i < 16; i++)
      chk(wr_regs[i*8 +: 8] == exp_wr[i], tag, wr_regs[i*8 +: 8], exp_wr[i]);
  endtask

  task automatic clear_model();
    for (int i = 0; i < 16; i++) begin
      exp_wr[i] = 8'h00;
      exp_rd[i] = 8'h00;
    end
    m_addr = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk(cmd_ready == 1'b1, "R9 ready after reset", {7'd0, cmd_ready}, 8'd1);
    chk(rsp_valid == 1'b0, "R9 no response after reset", {7'd0, rsp_valid}, 8'd0);
    check_wr("R9 write bank cleared");
    @(negedge clk);

    for (int i = 0; i < 16; i++) load_rd(i, 8'(8'hA3 ^ (i * 29)));

    // R2 R3 R1 write and read-back separation (R4)
    set_addr(8'h03);
    wr(8'h5C);
    check_wr("R3 write committed");
    rd(2'b00);
    drain();
    chk(aux_seen == 1'b0, "R8 no aux for handled opcode", {7'd0, aux_seen}, 8'd0);

    // R5 out-of-range write dropped, read gives FF
    set_addr(8'h25);
    wr(8'h77);
    check_wr("R5 R10 out-of-range write ignored");
    rd(2'b00);

    // R6 increment across 0x0F -> 0x10
    set_addr(8'h0E);
    rd(2'b01); rd(2'b01); rd(2'b01); rd(2'b00);
    // R6 decrement back down
    set_addr(8'h11);
    rd(2'b11); rd(2'b11); rd(2'b11); rd(2'b00);
    // R6 wrap 0xFF -> 0x00 and 0x00 -> 0xFF
    set_addr(8'hFF);
    rd(2'b01); rd(2'b00);
    rd(2'b11); rd(2'b00);
    // bit1 without bit0 does not move
    set_addr(8'h07);
    rd(2'b10); rd(2'b00);
    drain();

    // R8 aux between data halves, state untouched
    set_addr(8'h02);
    send(8'h29);
    send(8'h7F);
    chk(aux_seen && aux_byte == 8'h7F, "R8 aux passthrough", aux_byte, 8'h7F);
    send(8'h5A);
    chk(aux_seen && aux_byte == 8'h5A, "R8 aux passthrough", aux_byte, 8'h5A);
    send(8'h36);
    exp_wr[2] = 8'h69;
    check_wr("R8 pending nibble kept across aux");
    rd(2'b00);

    // R4 read bank updated after write bank change
    load_rd(2, 8'h3E);
    rd(2'b00);
    drain();

    // R7 backpressure: burst of reads under a throttled consumer
    slow = 1'b1;
    set_addr(8'h0C);
    for (int k = 0; k < 7; k++) rd(2'b01);
    drain();
    slow = 1'b0;
    @(negedge clk);

    // R9 mid-run reset
    set_addr(8'h05);
    wr(8'hC4);
    check_wr("R3 second write");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_model();
    #1;
    check_wr("R9 write bank cleared by reset");
    rd(2'b00);
    drain();
    chk(exp_q.size() == 0, "R4 all responses received", 8'(exp_q.size()), 8'd0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule